// File: doc/BRIEF.md
# Programmable Divide-by-N Decoded Counter

A synchronous counter with ten one-hot decoded outputs whose cycle length can be cut short to any value N from 2 to 10, so the clock is divided by N. The count is held in a five-bit twisted-ring (Johnson) code, named as the ten states CNT0 through CNT9. Each decoded output is formed from one adjacent pair of state bits, and the carry output is the inverted top state bit.

On each rising clock edge with the inhibit input low, the state takes one of two transitions. STEP moves it to the next state in the ring CNT0 → CNT1 → … → CNT9 → CNT0. RESTART moves it back to CNT0 when the current state is the terminal state CNT(N−1). RESTART takes priority. The restart is fully synchronous, so the output for count N never appears. A third transition, RECOVER, returns any code that is not one of the ten named states to CNT0 on the next enabled edge.

The master reset is asynchronous and wins over everything else. For stages chained together, the carry output rises at each restart when N is 6 or more. For smaller N the carry stays high, and the count-0 output serves as the clock for the next stage.

Top module: `divn_counter`

## Requirements
- R1: While `rst` is high, the block shows count 0 (`dec_out` = 10'b00_0000_0001) and `carry_out` = 1. This takes effect at once, with no clock edge, whatever the values of `inhibit` and `clk`.
- R2: Exactly one bit of `dec_out` is high at all times. Bit k high means the count is k.
- R3: On a rising edge of `clk` with `inhibit` low and the count not at the terminal value, the count goes up by one, and 9 is followed by 0.
- R4: On a rising edge with `inhibit` high, the count is held unchanged.
- R5: With `n_sel` = N in the range 2..10, an enabled edge at count N−1 returns the count to 0. The cycle therefore lasts N clocks, and `dec_out[N]` never goes high when N < 10.
- R6: The `n_sel` values 0, 1 and 11 to 15 act as N = 10, so the count runs through the full 0..9 ring.
- R7: `carry_out` is 1 for counts 0 to 4 and 0 for counts 5 to 9.
- R8: With N from 6 to 10, `carry_out` rises exactly once every N enabled clocks, at the restart to count 0. With N from 2 to 5, `carry_out` never falls, and `dec_out[0]` is the stage-to-stage clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| rst | input | 1 | Asynchronous master reset, active high |
| inhibit | input | 1 | High: hold the count |
| n_sel | input | 4 | Terminal count N (2..10; other values mean 10) |
| dec_out | output | 10 | One-hot decoded count |
| carry_out | output | 1 | High for counts 0..4; cascade clock |

## Verification
The assertions assume that `rst`, `inhibit` and `n_sel` change only away from the rising clock edge. They also assume that reset is applied from time zero and released between edges. The restart and step properties take `n_sel` as sampled at the same edge as the count.

The stimulus meets these assumptions by changing every input on the falling edge. Reset is raised in mid-cycle only for the asynchronous check, and it is released on a falling edge. Random values of `n_sel` cover the full 0..15 range, including the values outside 2..10.

// File: rtl/divn_pkg.sv
package divn_pkg;
    localparam int JW   = 5;          // Johnson ring width
    localparam int NCNT = 2 * JW;     // number of decoded counts
    localparam int SELW = 4;          // width of the N selector
    localparam int CARRY_SPLIT = JW;  // carry high below this count

    typedef enum logic [JW-1:0] {
        CNT0 = 5'b00000,
        CNT1 = 5'b00001,
        CNT2 = 5'b00011,
        CNT3 = 5'b00111,
        CNT4 = 5'b01111,
        CNT5 = 5'b11111,
        CNT6 = 5'b11110,
        CNT7 = 5'b11100,
        CNT8 = 5'b11000,
        CNT9 = 5'b10000
    } jstate_t;

    // Johnson code of count k: ones fill from the bottom, then drain from the bottom
    function automatic logic [JW-1:0] code_of(input int k);
        logic [JW-1:0] c;
        for (int i = 0; i < JW; i++) begin
            if (k <= JW) c[i] = (i < k);
            else         c[i] = (i >= k - JW);
        end
        return c;
    endfunction

    // effective terminal count: out-of-range selections fall back to the full ring
    function automatic int term_of(input logic [SELW-1:0] n);
        if (n >= 2 && int'(n) <= NCNT) return int'(n);
        return NCNT;
    endfunction
endpackage

// File: rtl/divn_term.sv
module divn_term
    import divn_pkg::*;
(
    input  logic [SELW-1:0] n_sel,
    output jstate_t         last_st
);
    always_comb begin
        last_st = jstate_t'(code_of(term_of(n_sel) - 1));
    end
endmodule

// File: rtl/divn_next.sv
module divn_next
    import divn_pkg::*;
(
    input  jstate_t cur,
    input  jstate_t last_st,
    output jstate_t nxt
);
    jstate_t step_st;

    // STEP transition around the ring; RECOVER for any unnamed code
    always_comb begin
        unique case (cur)
            CNT0:    step_st = CNT1;
            CNT1:    step_st = CNT2;
            CNT2:    step_st = CNT3;
            CNT3:    step_st = CNT4;
            CNT4:    step_st = CNT5;
            CNT5:    step_st = CNT6;
            CNT6:    step_st = CNT7;
            CNT7:    step_st = CNT8;
            CNT8:    step_st = CNT9;
            CNT9:    step_st = CNT0;
            default: step_st = CNT0;
        endcase
    end

    // RESTART has priority over STEP
    always_comb begin
        if (cur == last_st) nxt = CNT0;
        else                nxt = step_st;
    end
endmodule

// File: rtl/divn_decode.sv
module divn_decode
    import divn_pkg::*;
(
    input  logic [JW-1:0]   st,
    output logic [NCNT-1:0] dec,
    output logic            carry
);
    for (genvar k = 0; k < NCNT; k++) begin : g_dec
        if (k == 0) begin : g_zero
            assign dec[k] = ~st[JW-1] & ~st[0];
        end else if (k < JW) begin : g_fill
            assign dec[k] = st[k-1] & ~st[k];
        end else if (k == JW) begin : g_full
            assign dec[k] = st[JW-1] & st[0];
        end else begin : g_drain
            assign dec[k] = ~st[k-JW-1] & st[k-JW];
        end
    end

    assign carry = ~st[JW-1];
endmodule

// File: rtl/divn_counter.sv
module divn_counter
    import divn_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            inhibit,
    input  logic [SELW-1:0] n_sel,
    output logic [NCNT-1:0] dec_out,
    output logic            carry_out
);
    jstate_t state_q;
    jstate_t state_d;
    jstate_t last_st;

    divn_term u_term (
        .n_sel   (n_sel),
        .last_st (last_st)
    );

    divn_next u_next (
        .cur     (state_q),
        .last_st (last_st),
        .nxt     (state_d)
    );

    // state register: asynchronous master reset, clock gated by inhibit
    always_ff @(posedge clk or posedge rst) begin
        if (rst)           state_q <= CNT0;
        else if (!inhibit) state_q <= state_d;
    end

    // output process: decode the ring pairs
    divn_decode u_dec (
        .st    (state_q),
        .dec   (dec_out),
        .carry (carry_out)
    );
endmodule

// File: rtl/divn_counter_chk.sv
module divn_counter_chk
    import divn_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            inhibit,
    input logic [SELW-1:0] n_sel,
    input logic [NCNT-1:0] dec_out,
    input logic            carry_out
);
    int   eff_n;
    logic at_last;

    always_comb begin
        eff_n   = term_of(n_sel);
        at_last = dec_out[eff_n - 1];
    end

    a_r1_reset: assert property (@(posedge clk)
        rst |-> (dec_out == NCNT'(1) && carry_out));

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(dec_out) == 1);

    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && !at_last) |=>
            (dec_out == {$past(dec_out[NCNT-2:0]), $past(dec_out[NCNT-1])}));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> $stable(dec_out));

    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && at_last) |=> dec_out[0]);

    a_r7_carry: assert property (@(posedge clk) disable iff (rst)
        carry_out == (|dec_out[CARRY_SPLIT-1:0]));
endmodule

bind divn_counter divn_counter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .inhibit   (inhibit),
    .n_sel     (n_sel),
    .dec_out   (dec_out),
    .carry_out (carry_out)
);

// File: tb/divn_counter_bench.sv
module divn_counter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inhibit = 1'b0;
    logic [3:0] n_sel = 4'd10;
    logic [9:0] dec_out;
    logic       carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cnt      = 0;

    divn_counter u_divn_counter (
        .clk       (clk),
        .rst       (rst),
        .inhibit   (inhibit),
        .n_sel     (n_sel),
        .dec_out   (dec_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int eff_n(input logic [3:0] n);
        if (n >= 2 && n <= 10) return int'(n);
        return 10;
    endfunction

    function automatic logic [9:0] exp_dec(input int c);
        return 10'b1 << c;
    endfunction

    function automatic logic exp_carry(input int c);
        return c < 5;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        chk(dec_out == exp_dec(cnt), tag, dec_out, exp_dec(cnt));
        chk($countones(dec_out) == 1, "R2", dec_out, exp_dec(cnt));
        chk(carry_out == exp_carry(cnt), "R7", {9'd0, carry_out}, {9'd0, exp_carry(cnt)});
    endtask

    // one clock: inputs already set at a falling edge
    task automatic step(input logic inh, input string tag);
        inhibit = inh;
        @(posedge clk);
        if (!inh) begin
            if (cnt == eff_n(n_sel) - 1) cnt = 0;
            else                         cnt = (cnt + 1) % 10;
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk(dec_out == 10'd1 && carry_out, "R1", dec_out, 10'd1);
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL R3 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int rises;
        logic prev_c;
        void'($urandom(32'd2024));

        // R1: reset state before any edge, then held through edges with inhibit toggling
        #2;
        chk(dec_out == 10'd1, "R1", dec_out, 10'd1);
        chk(carry_out == 1'b1, "R1", {9'd0, carry_out}, 10'd1);
        inhibit = 1'b1;
        @(negedge clk);
        chk(dec_out == 10'd1 && carry_out, "R1", dec_out, 10'd1);
        inhibit = 1'b0;
        @(negedge clk);
        chk(dec_out == 10'd1 && carry_out, "R1", dec_out, 10'd1);
        rst = 1'b0;

        // R3: full ring with N=10, including the 9 to 0 wrap
        n_sel = 4'd10;
        for (int i = 0; i < 12; i++) step(1'b0, "R3");

        // R4: inhibit holds the count
        for (int i = 0; i < 5; i++) step(1'b1, "R4");
        step(1'b0, "R3");

        // R1: asynchronous reset mid-run overrides clock and inhibit
        for (int i = 0; i < 5; i++) step(1'b0, "R3");
        @(negedge clk);
        #1;
        inhibit = 1'b1;
        rst = 1'b1;
        #1;
        chk(dec_out == 10'd1, "R1", dec_out, 10'd1);
        chk(carry_out == 1'b1, "R1", {9'd0, carry_out}, 10'd1);
        @(negedge clk);
        chk(dec_out == 10'd1, "R1", dec_out, 10'd1);
        rst = 1'b0;
        inhibit = 1'b0;
        cnt = 0;

        // R6: out-of-range selections run the full ring
        for (int v = 0; v < 16; v++) begin
            if (v >= 2 && v <= 10) continue;
            do_reset();
            n_sel = 4'(v);
            for (int i = 0; i < 11; i++) step(1'b0, "R6");
        end

        // R5 and R8: each N, three full cycles, counting carry rises
        for (int nv = 2; nv <= 10; nv++) begin
            do_reset();
            n_sel = 4'(nv);
            rises = 0;
            prev_c = carry_out;
            for (int i = 0; i < 3 * nv; i++) begin
                step(1'b0, "R5");
                chk(!(nv < 10 && dec_out[nv % 10]), "R5", dec_out, exp_dec(cnt));
                if (carry_out && !prev_c) rises++;
                prev_c = carry_out;
            end
            chk(rises == ((nv >= 6) ? 3 : 0), "R8", 10'(rises), 10'((nv >= 6) ? 3 : 0));
            chk(dec_out[0] == 1'b1, "R8", dec_out, 10'd1);
        end

        // random phase: R3/R4/R5/R6 under mixed selections and inhibit
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 40 == 0) n_sel = 4'($urandom % 16);
            if ($urandom % 4 == 0)             step(1'b1, "R4");
            else if (eff_n(n_sel) != n_sel)    step(1'b0, "R6");
            else                               step(1'b0, "R5");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule